// File: doc/BRIEF.md
# Presettable Binary/Decade Up/Down Counter

A four-bit synchronous counter whose modulus is picked while it runs: sixteen states in binary mode, ten states (0 to 9) in decade mode. It counts up or down on the rising clock edge, but only while its active-low carry input is low. Its active-low carry output goes low when the stage is at the last state for the current direction and modulus. Several stages can be chained this way: the carry output of one stage drives the carry input of the next. The carry path is combinational, so the enable ripples through the chain within one cycle.

A parallel preset word is loaded whenever the preset enable is high. The preset is level-sensitive and transparent. While the enable is high, the count output shows the preset word in the same cycle, with no clock edge needed. The held state tracks the word on every edge, and no counting takes place. When the enable drops, the counter holds the last preset word until the next edge on which counting is enabled. In decade mode, a preset of 10 to 15 leaves the legal range after a single counting edge and cannot trap the counter.

The count register uses an active-low asynchronous reset that is released synchronously, and it resets to zero.

Top module: `ud_bcd_counter`

## Requirements
- R1: While the reset is asserted, and after it is released with preset enable low and carry-in high, the count output is 0.
- R2: While preset enable is 1, the count output equals the preset word in the same cycle, before any clock edge.
- R3: Preset enable overrides carry-in and direction. After an edge with preset enable 1, and once the enable drops, the count equals the preset word sampled at that edge, even with carry-in low.
- R4: With preset enable 0 and carry-in 1, a clock edge leaves the count unchanged.
- R5: In binary mode (mode select 1) with direction 1 (up), each enabled edge adds 1 modulo 16, so 15 is followed by 0.
- R6: In binary mode with direction 0 (down), each enabled edge subtracts 1 modulo 16, so 0 is followed by 15.
- R7: In decade mode (mode select 0) counting up, legal values 0 to 8 increment and 9 is followed by 0.
- R8: In decade mode counting down, values 1 to 9 decrement and 0 is followed by 9.
- R9: In decade mode, an out-of-range value from 10 to 15 moves on the next enabled edge to 0 when counting up, or to 9 when counting down.
- R10: Carry-out is 0 exactly when carry-in is 0 and the visible count is at the terminal value: 15 in binary up, 9 in decade up, and 0 when counting down in either mode. Otherwise carry-out is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| dir_up | input | 1 | Direction: 1 counts up, 0 counts down |
| mode_bin | input | 1 | Modulus: 1 selects binary (16 states), 0 selects decade (10 states) |
| carry_in_n | input | 1 | Active-low count enable / cascade input |
| ld_en | input | 1 | Level-sensitive preset enable |
| ld_word | input | 4 | Preset word |
| count_o | output | 4 | Visible count |
| carry_out_n | output | 1 | Active-low terminal-count / cascade output |

## Verification
The hardest states to reach from the ports are the decade-mode states 10 to 15. Normal counting never enters them, and only the preset can put the counter there. The bench therefore starts every trial with a preset: it sweeps all sixteen start values under all four combinations of modulus and direction. It checks the transparent preset value, the carry output with carry-in high and low, one enabled edge, one held edge, and a preset that overrides an active count request. Each expected value is computed arithmetically from the start value.

// File: rtl/ud_cnt_pkg.sv
package ud_cnt_pkg;

  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } dir_e;

  typedef enum logic {
    MOD_DECADE = 1'b0,
    MOD_BINARY = 1'b1
  } modsel_e;

  typedef struct packed {
    logic load;
    logic count;
  } reg_ctl_t;

endpackage

// File: rtl/ud_rst_sync.sv
module ud_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);

  generate
    if (STAGES <= 1) begin : g_single
      logic flop;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flop <= 1'b0;
        else        flop <= 1'b1;
      end
      assign rst_q_n = flop;
    end else begin : g_chain
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], 1'b1};
      end
      assign rst_q_n = chain[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/ud_step.sv
module ud_step
  import ud_cnt_pkg::*;
#(
  parameter int WIDTH    = 4,
  parameter int DEC_LAST = 9
) (
  input  logic [WIDTH-1:0] cur,
  input  dir_e             dir,
  input  modsel_e          msel,
  output logic [WIDTH-1:0] nxt,
  output logic             at_term
);

  localparam logic [WIDTH-1:0] ZERO     = '0;
  localparam logic [WIDTH-1:0] BIN_LAST = '1;
  localparam logic [WIDTH-1:0] DEC_TOP  = WIDTH'(DEC_LAST);
  localparam logic [WIDTH-1:0] ONE      = WIDTH'(1);

  logic [WIDTH-1:0] inc_v;
  logic [WIDTH-1:0] dec_v;
  logic             out_of_range;

  always_comb begin
    inc_v        = cur + ONE;
    dec_v        = cur - ONE;
    out_of_range = (cur > DEC_TOP);
    nxt          = cur;
    at_term      = 1'b0;
    unique case (msel)
      MOD_BINARY: begin
        if (dir == DIR_UP) begin
          nxt     = inc_v;
          at_term = (cur == BIN_LAST);
        end else begin
          nxt     = dec_v;
          at_term = (cur == ZERO);
        end
      end
      MOD_DECADE: begin
        if (dir == DIR_UP) begin
          nxt     = (out_of_range || cur == DEC_TOP) ? ZERO : inc_v;
          at_term = (cur == DEC_TOP);
        end else begin
          nxt     = (out_of_range || cur == ZERO) ? DEC_TOP : dec_v;
          at_term = (cur == ZERO);
        end
      end
      default: begin
        nxt     = cur;
        at_term = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/ud_state_reg.sv
module ud_state_reg
  import ud_cnt_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_q_n,
  input  reg_ctl_t         ctl,
  input  logic [WIDTH-1:0] load_val,
  input  logic [WIDTH-1:0] step_val,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] d;
  logic             en;

  always_comb begin
    en = ctl.load | ctl.count;
    d  = q;
    if (ctl.load)       d = load_val;
    else if (ctl.count) d = step_val;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)  q <= '0;
    else if (en)   q <= d;
  end

  // R1: the first edge after reset release finds the register cleared
  p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_q_n)
    $rose(rst_q_n) |-> (q == '0));

  // R3: a load edge captures the preset word
  p_load_capture_r3: assert property (@(posedge clk) disable iff (!rst_q_n)
    ctl.load |=> (q == $past(load_val)));

endmodule

// File: rtl/ud_bcd_counter.sv
module ud_bcd_counter
  import ud_cnt_pkg::*;
#(
  parameter int WIDTH       = 4,
  parameter int DEC_LAST    = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dir_up,
  input  logic             mode_bin,
  input  logic             carry_in_n,
  input  logic             ld_en,
  input  logic [WIDTH-1:0] ld_word,
  output logic [WIDTH-1:0] count_o,
  output logic             carry_out_n
);

  localparam logic [WIDTH-1:0] BIN_LAST = '1;
  localparam logic [WIDTH-1:0] DEC_TOP  = WIDTH'(DEC_LAST);

  logic             rst_q_n;
  logic [WIDTH-1:0] q;
  logic [WIDTH-1:0] step_val;
  logic             at_term;
  reg_ctl_t         ctl;
  dir_e             dir;
  modsel_e          msel;

  assign dir  = dir_e'(dir_up);
  assign msel = modsel_e'(mode_bin);

  ud_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  always_comb begin
    ctl.load  = ld_en;
    ctl.count = ~ld_en & ~carry_in_n;
  end

  // Transparent preset: the word is visible before any clock edge
  assign count_o = ld_en ? ld_word : q;

  ud_step #(.WIDTH(WIDTH), .DEC_LAST(DEC_LAST)) u_step (
    .cur     (count_o),
    .dir     (dir),
    .msel    (msel),
    .nxt     (step_val),
    .at_term (at_term)
  );

  ud_state_reg #(.WIDTH(WIDTH)) u_reg (
    .clk      (clk),
    .rst_q_n  (rst_q_n),
    .ctl      (ctl),
    .load_val (ld_word),
    .step_val (step_val),
    .q        (q)
  );

  assign carry_out_n = ~(~carry_in_n & at_term);

  // R2: preset word passes straight to the output
  p_preset_pass_r2: assert property (@(posedge clk) disable iff (!rst_q_n)
    ld_en |-> (count_o == ld_word));

  // R4: disabled count holds
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!ld_en && carry_in_n) |=> $stable(q));

  // R5: binary up wraps at the top
  p_bin_up_wrap_r5: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!ld_en && !carry_in_n && mode_bin && dir_up && q == BIN_LAST) |=> (q == '0));

  // R6: binary down wraps at zero
  p_bin_dn_wrap_r6: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!ld_en && !carry_in_n && mode_bin && !dir_up && q == '0) |=> (q == BIN_LAST));

  // R7: decade up wraps after the last digit
  p_dec_up_wrap_r7: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!ld_en && !carry_in_n && !mode_bin && dir_up && q == DEC_TOP) |=> (q == '0));

  // R8: decade down wraps to the last digit
  p_dec_dn_wrap_r8: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!ld_en && !carry_in_n && !mode_bin && !dir_up && q == '0) |=> (q == DEC_TOP));

  // R9: an out-of-range decade value is left on the next counting edge
  p_dec_recover_r9: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!ld_en && !carry_in_n && !mode_bin && q > DEC_TOP) |=> (q <= DEC_TOP));

  // R10: carry-out only fires while carry-in is active
  p_carry_gate_r10: assert property (@(posedge clk) disable iff (!rst_q_n)
    !carry_out_n |-> !carry_in_n);

endmodule

// File: tb/tb_ud_bcd_counter.sv
module tb_ud_bcd_counter;

  logic       clk;
  logic       rst_n;
  logic       dir_up;
  logic       mode_bin;
  logic       carry_in_n;
  logic       ld_en;
  logic [3:0] ld_word;
  logic [3:0] count_o;
  logic       carry_out_n;

  int n_checks;
  int n_fail;

  ud_bcd_counter dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .dir_up      (dir_up),
    .mode_bin    (mode_bin),
    .carry_in_n  (carry_in_n),
    .ld_en       (ld_en),
    .ld_word     (ld_word),
    .count_o     (count_o),
    .carry_out_n (carry_out_n)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int model_next(input int s, input bit up, input bit bin);
    if (bin) return up ? (s + 1) % 16 : (s + 15) % 16;
    if (s > 9) return up ? 0 : 9;
    return up ? (s + 1) % 10 : (s + 9) % 10;
  endfunction

  function automatic bit model_term(input int s, input bit up, input bit bin);
    if (!up) return (s == 0);
    return bin ? (s == 15) : (s == 9);
  endfunction

  function automatic string step_req(input int s, input bit up, input bit bin);
    if (bin) return up ? "R5" : "R6";
    if (s > 9) return "R9";
    return up ? "R7" : "R8";
  endfunction

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    n_checks   = 0;
    n_fail     = 0;
    rst_n      = 1'b0;
    dir_up     = 1'b1;
    mode_bin   = 1'b1;
    carry_in_n = 1'b1;
    ld_en      = 1'b0;
    ld_word    = 4'd0;
    repeat (3) @(negedge clk);
    #1 chk("R1 count in reset", int'(count_o), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1 chk("R1 count after release", int'(count_o), 0);

    for (int b = 0; b < 2; b++) begin
      for (int u = 0; u < 2; u++) begin
        for (int s = 0; s < 16; s++) begin
          int nx;
          @(negedge clk);
          mode_bin   = 1'(b);
          dir_up     = 1'(u);
          carry_in_n = 1'b1;
          ld_en      = 1'b1;
          ld_word    = 4'(s);
          #1 chk("R2 transparent preset", int'(count_o), s);
          @(negedge clk);
          ld_en = 1'b0;
          ld_word = 4'(15 - s);
          #1 chk("R3 preset held", int'(count_o), s);
          chk("R10 carry idle", int'(carry_out_n), 1);
          carry_in_n = 1'b0;
          #1 chk("R10 carry terminal", int'(carry_out_n),
                 model_term(s, 1'(u), 1'(b)) ? 0 : 1);
          @(negedge clk);
          carry_in_n = 1'b1;
          nx = model_next(s, 1'(u), 1'(b));
          #1 chk(step_req(s, 1'(u), 1'(b)), int'(count_o), nx);
          @(negedge clk);
          #1 chk("R4 hold", int'(count_o), nx);
          ld_en      = 1'b1;
          ld_word    = 4'(s ^ 5);
          carry_in_n = 1'b0;
          @(negedge clk);
          ld_en      = 1'b0;
          carry_in_n = 1'b1;
          #1 chk("R3 preset overrides count", int'(count_o), s ^ 5);
        end
      end
    end

    // Long run in decade up across several wraps
    @(negedge clk);
    mode_bin = 1'b0;
    dir_up   = 1'b1;
    ld_en    = 1'b1;
    ld_word  = 4'd7;
    @(negedge clk);
    ld_en      = 1'b0;
    carry_in_n = 1'b0;
    for (int k = 1; k <= 25; k++) begin
      @(negedge clk);
      #1 chk("R7 run", int'(count_o), (7 + k) % 10);
    end
    carry_in_n = 1'b1;

    // Reset while holding a nonzero count
    @(negedge clk);
    ld_en   = 1'b1;
    ld_word = 4'd12;
    @(negedge clk);
    ld_en = 1'b0;
    rst_n = 1'b0;
    #1 chk("R1 async clear", int'(count_o), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1 chk("R1 stays zero", int'(count_o), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule